// File: doc/BRIEF.md
# LCD Frame/Palette Load Sequencer

This block is the control and status core of a small LCD controller. A DMA-style source feeds it a stream of 16-bit words over a valid/ready handshake. When software sets the enable bit, a two-bit load mode chooses what the stream carries:
- a colour palette only,
- frame pixels only,
- a palette followed at once by frame pixels.

Palette words are written into an internal lookup RAM. The first palette word carries a pixel-depth code in its top nibble, and that code sets how many entries follow. Frame words pass straight to the display path whenever that path asks for a pixel.

Software sees a control register and a status register. The control register holds the enable bit, four interrupt mask bits and the load mode. The status register holds four sticky bits: frame done, palette loaded, input underflow and sync lost. Each bit has its own clearing rule, tied to enable and disable rather than to a plain write-1. Clearing enable in the middle of a frame does not cut the frame off. The block finishes the frame it is on, then raises frame done.

Top module: `lcd_load_seq`

## Requirements
- R1: After reset, `ctrl_q`, `stat_q` and `irq` are all zero and `s_ready` is low.
- R2: Control layout: bit 0 is enable, bits 4:1 are the masks for status bits 3:0, and bits 21:20 are the load mode. A write that sets enable while it is clear starts a load. Mode 01 loads the palette only, 10 loads frame data only, 00 loads the palette then frame data, and 11 acts as frame only.
- R3: Palette words go to consecutive RAM entries starting at entry 0. Entry 0 is the header, and bits 15:12 of the header are a depth code, shown on `pal_code`. Code 3 gives 256 entries and any other code gives 16. `pal_raddr` reads an entry back one cycle later.
- R4: Status bit 1 (palette loaded) sets on the clock edge that accepts the last palette word. In mode 01 the stream then stalls, with `s_ready` low.
- R5: In mode 00 the frame phase begins on the cycle right after the last palette word, with no idle cycle.
- R6: In the frame phase, `s_ready` follows `pix_req`, `pix_valid` is `pix_req` AND `s_valid`, and `pix_data` is `s_data`. While enable stays set, a word with `s_last` starts the next frame without a pause.
- R7: Status bit 2 (underflow) sets when `pix_req` is high and `s_valid` is low in the frame phase while enabled. It never sets without `pix_req`.
- R8: Status bit 3 (sync lost) sets when `sync_err` is high while enabled.
- R9: If enable is cleared during the frame phase, words keep flowing until the word with `s_last` is accepted. At that edge status bit 0 (done) sets and `s_ready` drops. Clearing enable outside the frame phase sets done at once.
- R10: Done stays set, and a write-1 to it is ignored, until a write sets enable again. That write clears done.
- R11: Clearing enable clears status bits 1, 2 and 3. A write-1 to bit 2 or bit 3 has no effect.
- R12: A write-1 to status bit 1 clears it only while the load mode is 01. If the last palette word is accepted in the same cycle as that write, the bit is set.
- R13: `irq` is the OR, over the four status bits, of each status bit AND its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write value |
| stat_we | input | 1 | Status write-1-to-clear strobe |
| stat_wdata | input | 4 | Status bits to clear |
| sync_err | input | 1 | Sync-lost event from the timing path |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DATA_W | Stream word |
| s_last | input | 1 | Marks the last word of a frame |
| s_ready | output | 1 | Stream word accepted |
| pix_req | input | 1 | Display path asks for a pixel |
| pix_valid | output | 1 | Pixel word present |
| pix_data | output | DATA_W | Pixel word |
| pal_raddr | input | PAL_AW | Palette read address |
| pal_rdata | output | DATA_W | Palette read data |
| pal_code | output | 4 | Depth code from the palette header |
| ctrl_q | output | 32 | Control register value |
| stat_q | output | 4 | Status register value |
| irq | output | 1 | Interrupt request |

## Verification
Two functions of this block can act on the same cycle:
- the edge that accepts the final palette word, which sets palette-loaded;
- a software write-1 that clears that same bit in palette-only mode.

The bench provokes this by driving the sixteenth palette word and the status clear strobe in one cycle. It then expects the bit to read back as set, because the set wins.

A second overlap is a disable write while a frame is in flight. In that cycle the underflow bit would set, but the disable clear must win. The bench expects all of status bits 1 to 3 to read zero while `s_ready` stays high.

// File: rtl/lcd_load_seq_pkg.sv
package lcd_load_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PAL  = 2'd1,
      PH_FRM  = 2'd2
   } phase_e;

   localparam int CTRL_W     = 32;
   localparam int CB_EN      = 0;
   localparam int CB_MASK_LO = 1;
   localparam int MODE_LO    = 20;

   localparam logic [1:0] LM_BOTH = 2'b00;
   localparam logic [1:0] LM_PAL  = 2'b01;
   localparam logic [1:0] LM_FRM  = 2'b10;

   localparam int ST_DONE = 0;
   localparam int ST_PAL  = 1;
   localparam int ST_UF   = 2;
   localparam int ST_SYNC = 3;
   localparam int STAT_W  = 4;
endpackage

// File: rtl/lcd_load_seq_palram.sv
module lcd_load_seq_palram #(
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter bit RD_REG = 1'b1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   initial begin
      assert (AW > 0 && AW <= 10) else $error("palram: AW out of range");
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         logic [DW-1:0] rd_q;
         always_ff @(posedge clk) rd_q <= mem[raddr];
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/lcd_load_seq_regs.sv
module lcd_load_seq_regs
   import lcd_load_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              stat_we,
   input  logic [STAT_W-1:0] stat_wdata,
   input  logic              pal_set,
   input  logic              uf_evt,
   input  logic              sync_err,
   input  logic              done_evt,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [STAT_W-1:0] stat_q,
   output logic              irq,
   output logic              en_q,
   output logic [1:0]        mode_q,
   output logic              en_rise,
   output logic              en_fall
);
   logic              en_r;
   logic [STAT_W-1:0] mask_r;
   logic [1:0]        mode_r;
   logic [STAT_W-1:0] hard_clr, set_v, soft_clr;
   logic              unused_wbits;

   assign unused_wbits = ^{ctrl_wdata[CTRL_W-1:MODE_LO+2],
                           ctrl_wdata[MODE_LO-1:STAT_W+1],
                           stat_wdata[ST_DONE], stat_wdata[ST_UF],
                           stat_wdata[ST_SYNC]};

   initial begin
      assert (MODE_LO > STAT_W) else $error("regs: mask field overlaps mode");
   end

   assign en_rise = ctrl_we &  ctrl_wdata[CB_EN] & ~en_r;
   assign en_fall = ctrl_we & ~ctrl_wdata[CB_EN] &  en_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_r   <= 1'b0;
         mask_r <= '0;
         mode_r <= LM_BOTH;
      end else if (ctrl_we) begin
         en_r   <= ctrl_wdata[CB_EN];
         mask_r <= ctrl_wdata[STAT_W:CB_MASK_LO];
         mode_r <= ctrl_wdata[MODE_LO+1:MODE_LO];
      end
   end

   always_comb begin
      ctrl_q                         = '0;
      ctrl_q[CB_EN]                  = en_r;
      ctrl_q[STAT_W:CB_MASK_LO]      = mask_r;
      ctrl_q[MODE_LO+1:MODE_LO]      = mode_r;
   end

   always_comb begin
      hard_clr          = '0;
      set_v             = '0;
      soft_clr          = '0;
      hard_clr[ST_DONE] = en_rise;
      hard_clr[ST_PAL]  = en_fall;
      hard_clr[ST_UF]   = en_fall;
      hard_clr[ST_SYNC] = en_fall;
      set_v[ST_DONE]    = done_evt;
      set_v[ST_PAL]     = pal_set;
      set_v[ST_UF]      = uf_evt;
      set_v[ST_SYNC]    = sync_err & en_r;
      soft_clr[ST_PAL]  = stat_we & stat_wdata[ST_PAL] & (mode_r == LM_PAL);
   end

   generate
      for (genvar b = 0; b < STAT_W; b++) begin : g_stat
         always_ff @(posedge clk) begin
            if (!rst_n)           stat_q[b] <= 1'b0;
            else if (hard_clr[b]) stat_q[b] <= 1'b0;
            else if (set_v[b])    stat_q[b] <= 1'b1;
            else if (soft_clr[b]) stat_q[b] <= 1'b0;
         end
      end
   endgenerate

   assign irq    = |(stat_q & mask_r);
   assign en_q   = en_r;
   assign mode_q = mode_r;

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[ST_DONE] && !en_rise) |=> stat_q[ST_DONE]); // R10
   AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      en_fall |=> (stat_q[ST_SYNC:ST_PAL] == '0)); // R11
   AST_PAL_W1C_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[ST_PAL] && mode_r != LM_PAL && !en_fall) |=> stat_q[ST_PAL]); // R12
endmodule

// File: rtl/lcd_load_seq_fsm.sv
module lcd_load_seq_fsm
   import lcd_load_seq_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int PAL_DEPTH = 256,
   parameter int SMALL_N   = 16,
   parameter int FULL_CODE = 3,
   parameter int PAL_AW    = $clog2(PAL_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_q,
   input  logic              en_rise,
   input  logic              en_fall,
   input  logic [1:0]        wr_mode,
   input  logic [1:0]        mode_q,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   input  logic              pix_req,
   output logic              pix_valid,
   output logic [DATA_W-1:0] pix_data,
   output logic              pal_we,
   output logic [PAL_AW-1:0] pal_waddr,
   output logic [DATA_W-1:0] pal_wdata,
   output logic              pal_set,
   output logic              done_evt,
   output logic              uf_evt,
   output logic              in_frame,
   output logic [3:0]        pal_code
);
   localparam logic [PAL_AW-1:0] FULL_LAST  = PAL_AW'(PAL_DEPTH - 1);
   localparam logic [PAL_AW-1:0] SMALL_LAST = PAL_AW'(SMALL_N - 1);
   localparam logic [3:0]        FULL_C     = 4'(FULL_CODE);

   phase_e            state;
   logic [PAL_AW-1:0] idx;
   logic [3:0]        code_r;
   logic [3:0]        hdr_code;
   logic [PAL_AW-1:0] last_idx;
   logic              beat, pal_beat, pal_end, frm_end;

   initial begin
      assert (DATA_W >= 16) else $error("fsm: header needs 16-bit words");
      assert (SMALL_N >= 2 && SMALL_N <= PAL_DEPTH) else $error("fsm: SMALL_N");
      assert ((1 << PAL_AW) == PAL_DEPTH) else $error("fsm: depth not 2^n");
   end

   always_comb begin
      unique case (state)
         PH_PAL:  s_ready = 1'b1;
         PH_FRM:  s_ready = pix_req;
         default: s_ready = 1'b0;
      endcase
   end

   assign beat     = s_valid & s_ready;
   assign pal_beat = beat & (state == PH_PAL);
   assign hdr_code = (idx == '0) ? s_data[15:12] : code_r;
   assign last_idx = (hdr_code == FULL_C) ? FULL_LAST : SMALL_LAST;
   assign pal_end  = pal_beat & (idx == last_idx);
   assign frm_end  = beat & (state == PH_FRM) & s_last & ~en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= PH_IDLE;
         idx    <= '0;
         code_r <= '0;
      end else begin
         if (pal_beat && idx == '0) code_r <= s_data[15:12];
         if (en_rise) begin
            state <= (wr_mode == LM_BOTH || wr_mode == LM_PAL) ? PH_PAL : PH_FRM;
            idx   <= '0;
         end else if (en_fall && state != PH_FRM) begin
            state <= PH_IDLE;
            idx   <= '0;
         end else begin
            unique case (state)
               PH_PAL: begin
                  if (pal_end) begin
                     idx   <= '0;
                     state <= (mode_q == LM_BOTH) ? PH_FRM : PH_IDLE;
                  end else if (pal_beat) begin
                     idx <= idx + 1'b1;
                  end
               end
               PH_FRM: if (frm_end) state <= PH_IDLE;
               default: state <= PH_IDLE;
            endcase
         end
      end
   end

   assign pal_we    = pal_beat;
   assign pal_waddr = idx;
   assign pal_wdata = s_data;
   assign pal_set   = pal_end;
   assign done_evt  = (en_fall & (state != PH_FRM)) | (frm_end & ~en_rise);
   assign in_frame  = (state == PH_FRM);
   assign uf_evt    = in_frame & en_q & pix_req & ~s_valid;
   assign pix_valid = in_frame & pix_req & s_valid;
   assign pix_data  = s_data;
   assign pal_code  = code_r;

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_PAL && idx != '0 && code_r != FULL_C) |-> (idx <= SMALL_LAST)); // R3
   AST_STALL_AFTER_PAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_set && mode_q == LM_PAL && !en_rise) |=> !s_ready); // R4
   AST_BOTH_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_set && mode_q == LM_BOTH && !en_rise && !en_fall) |=> in_frame); // R5
endmodule

// File: rtl/lcd_load_seq.sv
module lcd_load_seq
   import lcd_load_seq_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int PAL_DEPTH  = 256,
   parameter int SMALL_N    = 16,
   parameter int FULL_CODE  = 3,
   parameter bit PAL_RD_REG = 1'b1,
   localparam int PAL_AW    = $clog2(PAL_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [31:0]       ctrl_wdata,
   input  logic              stat_we,
   input  logic [3:0]        stat_wdata,
   input  logic              sync_err,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   input  logic              pix_req,
   output logic              pix_valid,
   output logic [DATA_W-1:0] pix_data,
   input  logic [PAL_AW-1:0] pal_raddr,
   output logic [DATA_W-1:0] pal_rdata,
   output logic [3:0]        pal_code,
   output logic [31:0]       ctrl_q,
   output logic [3:0]        stat_q,
   output logic              irq
);
   logic              en_q, en_rise, en_fall;
   logic [1:0]        mode_q;
   logic              pal_we, pal_set, done_evt, uf_evt, in_frame;
   logic [PAL_AW-1:0] pal_waddr;
   logic [DATA_W-1:0] pal_wdata;

   initial begin
      assert (PAL_DEPTH >= 16 && PAL_DEPTH <= 1024) else $error("top: PAL_DEPTH");
      assert (FULL_CODE >= 0 && FULL_CODE < 16) else $error("top: FULL_CODE");
   end

   lcd_load_seq_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .stat_we(stat_we), .stat_wdata(stat_wdata),
      .pal_set(pal_set), .uf_evt(uf_evt), .sync_err(sync_err),
      .done_evt(done_evt),
      .ctrl_q(ctrl_q), .stat_q(stat_q), .irq(irq),
      .en_q(en_q), .mode_q(mode_q), .en_rise(en_rise), .en_fall(en_fall)
   );

   lcd_load_seq_fsm #(
      .DATA_W(DATA_W), .PAL_DEPTH(PAL_DEPTH), .SMALL_N(SMALL_N),
      .FULL_CODE(FULL_CODE), .PAL_AW(PAL_AW)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .en_q(en_q), .en_rise(en_rise), .en_fall(en_fall),
      .wr_mode(ctrl_wdata[MODE_LO+1:MODE_LO]), .mode_q(mode_q),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .pix_req(pix_req), .pix_valid(pix_valid), .pix_data(pix_data),
      .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
      .pal_set(pal_set), .done_evt(done_evt), .uf_evt(uf_evt),
      .in_frame(in_frame), .pal_code(pal_code)
   );

   lcd_load_seq_palram #(
      .AW(PAL_AW), .DW(DATA_W), .RD_REG(PAL_RD_REG)
   ) u_palram (
      .clk(clk), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
      .raddr(pal_raddr), .rdata(pal_rdata)
   );

   AST_UF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && en_q && pix_req && !s_valid && !en_fall) |=> stat_q[ST_UF]); // R7
   AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && !en_q && s_valid && s_ready && s_last && !en_rise)
      |=> (stat_q[ST_DONE] && !s_ready)); // R9
endmodule

// File: tb/lcd_load_seq_bench.sv
module lcd_load_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic        stat_we = 1'b0;
   logic [3:0]  stat_wdata = '0;
   logic        sync_err = 1'b0;
   logic        s_valid = 1'b0;
   logic [15:0] s_data = '0;
   logic        s_last = 1'b0;
   logic        s_ready;
   logic        pix_req = 1'b1;
   logic        pix_valid;
   logic [15:0] pix_data;
   logic [7:0]  pal_raddr = '0;
   logic [15:0] pal_rdata;
   logic [3:0]  pal_code;
   logic [31:0] ctrl_q;
   logic [3:0]  stat_q;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q[$];

   always #10 clk = ~clk;

   lcd_load_seq u_lcd_load_seq (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .stat_we(stat_we), .stat_wdata(stat_wdata), .sync_err(sync_err),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .pix_req(pix_req), .pix_valid(pix_valid), .pix_data(pix_data),
      .pal_raddr(pal_raddr), .pal_rdata(pal_rdata), .pal_code(pal_code),
      .ctrl_q(ctrl_q), .stat_q(stat_q), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a pixel leaves the block (R6)
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (pix_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected pixel", {16'h0, pix_data}, 32'h0);
            else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk(pix_data == e, "R6 pixel order", {16'h0, pix_data}, {16'h0, e});
            end
         end
      end
   end

   task automatic wr_ctrl(input logic [31:0] v);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic wr_stat(input logic [3:0] v);
      stat_we = 1'b1; stat_wdata = v;
      @(negedge clk);
      stat_we = 1'b0;
   endtask

   task automatic send(input logic [15:0] d, input bit last, input bit frm,
                       output int waits);
      s_valid = 1'b1; s_data = d; s_last = last;
      #1;
      waits = 0;
      while (!s_ready && waits < 1000) begin
         @(negedge clk);
         #1;
         waits++;
      end
      if (frm) exp_q.push_back(d);
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic rd_pal(input logic [7:0] a, input logic [15:0] e, input string tag);
      pal_raddr = a;
      @(negedge clk);
      chk(pal_rdata == e, tag, {16'h0, pal_rdata}, {16'h0, e});
   endtask

   initial begin
      #4_000_000;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(ctrl_q == 0, "R1 ctrl", ctrl_q, 0);
      chk(stat_q == 0, "R1 stat", {28'h0, stat_q}, 0);
      chk(irq == 0 && s_ready == 0, "R1 irq/ready", {30'h0, irq, s_ready}, 0);

      // R2 palette-only load, 16 entries (code 4)
      wr_ctrl(32'h1F | (32'h1 << 20));
      #1 chk(s_ready == 1, "R2 palette phase ready", {31'h0, s_ready}, 1);
      send(16'h4ABC, 0, 0, w);
      for (int i = 1; i < 16; i++) send(16'h0100 + 16'(i), 0, 0, w);
      chk(stat_q == 4'b0010, "R4 pal loaded", {28'h0, stat_q}, 32'h2);
      chk(s_ready == 0, "R4 stall after palette", {31'h0, s_ready}, 0);
      chk(pal_code == 4'h4, "R3 depth code", {28'h0, pal_code}, 4);
      chk(irq == 1, "R13 irq on pal", {31'h0, irq}, 1);
      rd_pal(8'd0, 16'h4ABC, "R3 entry 0");
      rd_pal(8'd5, 16'h0105, "R3 entry 5");
      rd_pal(8'd15, 16'h010F, "R3 entry 15");

      // R12 write-1 clears palette-loaded in mode 01
      wr_stat(4'h2);
      chk(stat_q[1] == 0, "R12 w1c mode 01", {31'h0, stat_q[1]}, 0);
      chk(irq == 0, "R13 irq low", {31'h0, irq}, 0);

      // R9 disable outside frame sets DONE immediately
      wr_ctrl(32'h1E);
      chk(stat_q == 4'b0001, "R9 done on idle disable", {28'h0, stat_q}, 1);
      wr_stat(4'h1);
      chk(stat_q[0] == 1, "R10 done ignores w1c", {31'h0, stat_q[0]}, 1);

      // R5 mode 00: 256-entry palette then frame
      wr_ctrl(32'h1F);
      chk(stat_q[0] == 0, "R10 enable clears done", {31'h0, stat_q[0]}, 0);
      send(16'h3FA5, 0, 0, w);
      for (int k = 1; k < 256; k++) send(16'(k * 3), 0, 0, w);
      chk(stat_q[1] == 1, "R4 pal loaded mode 00", {31'h0, stat_q[1]}, 1);
      send(16'hA000, 0, 1, w);
      chk(w == 0, "R5 no dead cycle", w, 0);
      send(16'hA001, 0, 1, w);
      send(16'hA002, 0, 1, w);
      wr_stat(4'h2);
      chk(stat_q[1] == 1, "R12 w1c ignored mode 00", {31'h0, stat_q[1]}, 1);
      chk(stat_q[2] == 1, "R7 underflow", {31'h0, stat_q[2]}, 1);
      sync_err = 1'b1;
      @(negedge clk);
      sync_err = 1'b0;
      chk(stat_q[3] == 1, "R8 sync lost", {31'h0, stat_q[3]}, 1);
      wr_stat(4'hC);
      chk(stat_q[3:2] == 2'b11, "R11 w1c ignored", {30'h0, stat_q[3:2]}, 3);
      send(16'hA003, 0, 1, w);
      send(16'hA004, 0, 1, w);

      // R9 disable mid-frame drains to last
      wr_ctrl(32'h1E);
      chk(stat_q == 4'b0000, "R11 disable clears", {28'h0, stat_q}, 0);
      chk(s_ready == 1, "R9 frame continues", {31'h0, s_ready}, 1);
      send(16'hA005, 0, 1, w);
      send(16'hA006, 1, 1, w);
      chk(stat_q == 4'b0001, "R9 done after last", {28'h0, stat_q}, 1);
      chk(s_ready == 0, "R9 stream stops", {31'h0, s_ready}, 0);
      chk(pal_code == 4'h3, "R3 depth code 3", {28'h0, pal_code}, 3);
      rd_pal(8'd0, 16'h3FA5, "R3 big entry 0");
      rd_pal(8'd128, 16'h0180, "R3 big entry 128");
      rd_pal(8'd255, 16'h02FD, "R3 big entry 255");

      // R12 set wins over same-cycle clear
      wr_ctrl(32'h1F | (32'h1 << 20));
      send(16'h4000, 0, 0, w);
      for (int i = 1; i < 15; i++) send(16'h0200 + 16'(i), 0, 0, w);
      s_valid = 1'b1; s_data = 16'h020F; stat_we = 1'b1; stat_wdata = 4'h2;
      @(negedge clk);
      s_valid = 1'b0; stat_we = 1'b0;
      chk(stat_q[1] == 1, "R12 set wins", {31'h0, stat_q[1]}, 1);
      wr_stat(4'h2);

      // R2/R6 frame-only mode loops frames
      wr_ctrl(32'h1E);
      wr_ctrl(32'h1F | (32'h2 << 20));
      chk(s_ready == 1 && stat_q == 0, "R2 frame-only start", {27'h0, stat_q, s_ready}, 1);
      send(16'hB000, 0, 1, w);
      send(16'hB001, 1, 1, w);
      chk(s_ready == 1, "R6 frame loops", {31'h0, s_ready}, 1);
      send(16'hB002, 0, 1, w);
      pix_req = 1'b0; s_valid = 1'b1; s_data = 16'hBEEF;
      #1 chk(s_ready == 0 && pix_valid == 0, "R6 no request no beat",
             {30'h0, s_ready, pix_valid}, 0);
      @(negedge clk);
      s_valid = 1'b0;
      @(negedge clk);
      chk(stat_q[2] == 0, "R7 no underflow without request", {31'h0, stat_q[2]}, 0);
      pix_req = 1'b1;

      // R2 mode 11 acts as frame-only; R13 masking
      wr_ctrl(32'h1E);
      wr_ctrl(32'h1F | (32'h3 << 20));
      send(16'hC001, 0, 1, w);
      chk(stat_q[1] == 0 && s_ready == 1, "R2 mode 11 frame", {30'h0, stat_q[1], s_ready}, 1);
      wr_ctrl(32'h0);
      send(16'hC002, 1, 1, w);
      chk(stat_q[0] == 1 && irq == 0, "R13 masked done", {30'h0, stat_q[0], irq}, 2);
      wr_ctrl(32'h2);
      chk(irq == 1, "R13 unmasked done", {31'h0, irq}, 1);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule